// File: doc/BRIEF.md
# Reset and Stop-Wake Stabilization Sequencer

This block controls when a processor core may start running. It handles two cases: coming out of an external reset, and waking up from a low-power stop state. In both cases it holds the core until the clock has had time to settle. A mode bit picks one of two settling periods. The long period is meant for an oscillator that must fully settle. The short period is meant for a fast wake-up. When the wait is over, the block gives the core a single fetch-start pulse and raises the run enable.

During reset, the block floats the address, data and control pins straight away. It keeps them floating until a fixed 33-cycle delay after reset release has run out. While the core is running, a stop request puts it to sleep. A wake line, active low, brings it back. Each sample of the wake line passes through a two-flop synchronizer first. The wake line can work in one of two ways:
- **Edge-qualified mode:** a low level must be seen on two clock edges in a row.
- **Level mode:** the line must stay low for the whole settling count, or the wake-up is abandoned.

All delays are counted in core clock cycles by one down-counter.

Top module: `stabseq_top`

## Requirements
- R1: While `ext_rst_n` is low, `bus_float` is high in the same cycle, with no wait for a clock edge. Every edge that samples `ext_rst_n` low leaves `seq_state` at RESET, with `core_run` and `fetch_start` low.
- R2: The reset settling count is `LONG_CYC` edges when `mode_fast` is 0 and `RST_FAST_CYC` (128) edges when it is 1. It is counted from the first edge that samples reset low, and that edge counts as the first. `mode_fast` is sampled only at that entry edge.
- R3: The post-reset phase (POST) starts at the later of two edges: the first edge that samples `ext_rst_n` high, and the edge that completes the settling count. `fetch_start` rises at the edge `POST_CYC` (33) cycles after POST starts. `bus_float` stays high until that same edge.
- R4: If reset is released before the settling count ends, the state becomes RSTAB. The rest of the count runs out in RSTAB before POST starts.
- R5: `fetch_start` is a one-cycle pulse. It is given once each time RUN is entered. `core_run` is high exactly while `seq_state` is RUN.
- R6: A high `stop_req` is obeyed only in RUN. The edge that samples it moves the state to STOP and clears `core_run`. In every other state it has no effect.
- R7: `wake_n` passes through a two-flop synchronizer. When `wake_level` is 0, a wake from STOP needs a synchronized low on two edges in a row. A low that lasts one cycle leaves the block in STOP.
- R8: The wake settling phase (WSTAB) lasts `LONG_CYC` edges when `mode_fast` is 0 and `WAKE_FAST_CYC` (12) edges when it is 1. `mode_fast` is sampled at the edge that enters WSTAB. `fetch_start` rises at the edge that many cycles after entry.
- R9: When `wake_level` is 1, one synchronized low sample in STOP starts WSTAB. If a high sample arrives before the count ends, the state returns to STOP and the count is lost. The next wake then starts a full count.
- R10: `seq_state` uses these codes: RUN=0, RESET=1, RSTAB=2, POST=3, STOP=4, WSTAB=5. No other value ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| ext_rst_n | input | 1 | External reset, active low, sampled on the clock |
| mode_fast | input | 1 | 1 selects the short settling counts, 0 selects the long count |
| stop_req | input | 1 | Request to enter stop from RUN |
| wake_n | input | 1 | Wake interrupt line, active low, asynchronous |
| wake_level | input | 1 | 1 selects level wake, 0 selects edge-qualified wake |
| bus_float | output | 1 | Float the address, data and control pins |
| core_run | output | 1 | Core run enable |
| fetch_start | output | 1 | One-cycle pulse that starts the first fetch |
| seq_state | output | 3 | Current sequencer state, coded as in R10 |

## Verification
The settling sequence is exercised in two ways:
- **Reset held longer than the long count.** This tells the fixed 33-cycle post-reset delay apart from the settling count.
- **Short-mode reset released after 40 cycles, with `mode_fast` changed part-way.** This shows that the rest of the count is finished in RSTAB, and that the mode is sampled only on entry.

Wake is exercised in four ways:
- **A one-cycle edge pulse.** This must be rejected.
- **A held edge wake in fast mode.** This measures the two-sample qualification plus the 12-cycle count.
- **A level wake released mid-count, then asserted again.** This shows that the count is discarded and restarted in full.
- **A reset asserted during a wake.** This shows that reset takes priority.

A stop request is also held high during WSTAB and STOP, to show it is ignored outside RUN.

// File: rtl/stabseq_pkg.sv
package stabseq_pkg;

  typedef enum logic [2:0] {
    SQ_RUN   = 3'd0,
    SQ_RESET = 3'd1,
    SQ_RSTAB = 3'd2,
    SQ_POST  = 3'd3,
    SQ_STOP  = 3'd4,
    SQ_WSTAB = 3'd5
  } seq_state_e;

  function automatic logic is_float_state(input seq_state_e s);
    return (s == SQ_RESET) || (s == SQ_RSTAB) || (s == SQ_POST);
  endfunction

endpackage

// File: rtl/stabseq_sync2.sv
module stabseq_sync2 #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= {STAGES{RST_VAL}};
    else     shreg <= {shreg[STAGES-2:0], d};
  end

  assign q = shreg[STAGES-1];
endmodule

// File: rtl/stabseq_wake_qual.sv
module stabseq_wake_qual #(
  parameter int EDGE_MIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_act,
  input  logic level_mode,
  input  logic in_stop,
  input  logic in_wstab,
  output logic wake_start,
  output logic wake_drop
);
  localparam int RUN_W = $clog2(EDGE_MIN + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(EDGE_MIN - 1);

  // consecutive asserted samples seen while in stop, saturating
  logic [RUN_W-1:0] run_q;
  logic             edge_ok;

  always_ff @(posedge clk) begin
    if (rst)                     run_q <= '0;
    else if (!(wake_act && in_stop)) run_q <= '0;
    else if (run_q != RUN_SAT)   run_q <= run_q + 1'b1;
  end

  generate
    if (EDGE_MIN <= 1) begin : g_single
      assign edge_ok = 1'b1;
    end else begin : g_multi
      assign edge_ok = (run_q == RUN_SAT);
    end
  endgenerate

  assign wake_start = in_stop && wake_act && (level_mode || edge_ok);
  assign wake_drop  = in_wstab && level_mode && !wake_act;
endmodule

// File: rtl/stabseq_cnt.sv
module stabseq_cnt #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (step) begin
      if (cnt != '0) cnt <= cnt - 1'b1;
    end else begin
      cnt <= load_val;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/stabseq_top.sv
module stabseq_top
  import stabseq_pkg::*;
#(
  parameter int LONG_CYC      = 275000,
  parameter int RST_FAST_CYC  = 128,
  parameter int WAKE_FAST_CYC = 12,
  parameter int POST_CYC      = 33,
  parameter int SYNC_STAGES   = 2,
  parameter int EDGE_MIN      = 2
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       mode_fast,
  input  logic       stop_req,
  input  logic       wake_n,
  input  logic       wake_level,
  output logic       bus_float,
  output logic       core_run,
  output logic       fetch_start,
  output logic [2:0] seq_state
);
  localparam int MAX_CYC = (LONG_CYC > RST_FAST_CYC) ? LONG_CYC : RST_FAST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] RFAST_LD = CNT_W'(RST_FAST_CYC - 1);
  localparam logic [CNT_W-1:0] WFAST_LD = CNT_W'(WAKE_FAST_CYC - 1);
  localparam logic [CNT_W-1:0] POST_LD  = CNT_W'(POST_CYC - 1);

  logic rst;
  assign rst = ~ext_rst_n;

  seq_state_e       state_q, nxt;
  logic             float_q, run_q, fetch_q;
  logic             wake_sync, wake_act, wake_start, wake_drop;
  logic             step, cnt_zero;
  logic [CNT_W-1:0] load_val, cnt;

  stabseq_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (wake_n),
    .q   (wake_sync)
  );
  assign wake_act = ~wake_sync;

  stabseq_wake_qual #(.EDGE_MIN(EDGE_MIN)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .wake_act   (wake_act),
    .level_mode (wake_level),
    .in_stop    (state_q == SQ_STOP),
    .in_wstab   (state_q == SQ_WSTAB),
    .wake_start (wake_start),
    .wake_drop  (wake_drop)
  );

  stabseq_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .step     (step),
    .load_val (load_val),
    .cnt      (cnt),
    .zero     (cnt_zero)
  );

  always_comb begin
    nxt      = state_q;
    step     = 1'b0;
    load_val = '0;
    if (rst) begin
      nxt = SQ_RESET;
      if (state_q == SQ_RESET) step = 1'b1;
      else                     load_val = mode_fast ? RFAST_LD : LONG_LD;
    end else begin
      case (state_q)
        SQ_RESET, SQ_RSTAB: begin
          if (cnt_zero) begin
            nxt      = SQ_POST;
            load_val = POST_LD;
          end else begin
            nxt  = SQ_RSTAB;
            step = 1'b1;
          end
        end
        SQ_POST: begin
          if (cnt_zero) nxt = SQ_RUN;
          else          step = 1'b1;
        end
        SQ_RUN: begin
          if (stop_req) nxt = SQ_STOP;
        end
        SQ_STOP: begin
          if (wake_start) begin
            nxt      = SQ_WSTAB;
            load_val = mode_fast ? WFAST_LD : LONG_LD;
          end
        end
        SQ_WSTAB: begin
          if (wake_drop)     nxt = SQ_STOP;
          else if (cnt_zero) nxt = SQ_RUN;
          else               step = 1'b1;
        end
        default: nxt = SQ_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state_q <= nxt;
    run_q   <= (nxt == SQ_RUN);
    fetch_q <= (nxt == SQ_RUN) && (state_q != SQ_RUN);
    float_q <= is_float_state(nxt);
  end

  assign bus_float   = float_q | rst;
  assign core_run    = run_q;
  assign fetch_start = fetch_q;
  assign seq_state   = state_q;
endmodule

// File: rtl/stabseq_chk.sv
module stabseq_chk
  import stabseq_pkg::*;
(
  input logic       clk,
  input logic       ext_rst_n,
  input logic       stop_req,
  input logic       wake_level,
  input logic       wake_act,
  input logic       bus_float,
  input logic       core_run,
  input logic       fetch_start,
  input logic [2:0] seq_state
);
  assert_fetch_pulse_R5: assert property (@(posedge clk) disable iff (!ext_rst_n)
    fetch_start |=> !fetch_start);

  assert_fetch_runs_R5: assert property (@(posedge clk) disable iff (!ext_rst_n)
    fetch_start |-> core_run);

  assert_stop_drops_run_R6: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (seq_state == SQ_RUN && stop_req) |=> (!core_run && seq_state == SQ_STOP));

  assert_pins_driven_in_run_R3: assert property (@(posedge clk) disable iff (!ext_rst_n)
    core_run |-> !bus_float);

  assert_post_exits_to_run_R3: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (seq_state == SQ_POST) |=> (seq_state == SQ_POST || seq_state == SQ_RUN));

  assert_rstab_to_post_R4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (seq_state == SQ_RSTAB) |=> (seq_state == SQ_RSTAB || seq_state == SQ_POST));

  assert_wake_from_stop_R7: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(seq_state == SQ_WSTAB) |-> $past(seq_state) == SQ_STOP);

  assert_level_release_R9: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (seq_state == SQ_WSTAB && wake_level && !wake_act) |=> seq_state == SQ_STOP);

  assert_state_code_R10: assert property (@(posedge clk) disable iff (!ext_rst_n)
    seq_state <= 3'd5);
endmodule

bind stabseq_top stabseq_chk u_chk (
  .clk         (clk),
  .ext_rst_n   (ext_rst_n),
  .stop_req    (stop_req),
  .wake_level  (wake_level),
  .wake_act    (wake_act),
  .bus_float   (bus_float),
  .core_run    (core_run),
  .fetch_start (fetch_start),
  .seq_state   (seq_state)
);

// File: tb/stabseq_top_test.sv
`timescale 1ns/1ps
module stabseq_top_test;
  localparam int LONG  = 300;
  localparam int RFAST = 128;
  localparam int WFAST = 12;
  localparam int POST  = 33;
  // state codes from R10
  localparam int S_RUN = 0, S_RESET = 1, S_RSTAB = 2, S_POST = 3, S_STOP = 4, S_WSTAB = 5;

  logic clk = 1'b0;
  logic ext_rst_n = 1'b0, mode_fast = 1'b0, stop_req = 1'b0, wake_n = 1'b1, wake_level = 1'b0;
  logic bus_float, core_run, fetch_start;
  logic [2:0] seq_state;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  stabseq_top #(.LONG_CYC(LONG)) uut (
    .clk(clk), .ext_rst_n(ext_rst_n), .mode_fast(mode_fast), .stop_req(stop_req),
    .wake_n(wake_n), .wake_level(wake_level), .bus_float(bus_float),
    .core_run(core_run), .fetch_start(fetch_start), .seq_state(seq_state)
  );

  // behavioural reference model
  int m_st = -1, m_rem = 0, m_run_cnt = 0;
  bit m_s1 = 1, m_s2 = 1, m_fetch = 0, m_run = 0, m_float = 1;

  always @(posedge clk) begin
    bit a;
    int old;
    a = (m_s2 == 1'b0);
    old = m_st;
    if (!ext_rst_n) begin
      if (m_st != S_RESET) m_rem = (mode_fast ? RFAST : LONG) - 1;
      else if (m_rem > 0) m_rem = m_rem - 1;
      m_st = S_RESET;
      m_run_cnt = 0;
      m_s1 = 1; m_s2 = 1;
    end else begin
      case (old)
        S_RESET, S_RSTAB:
          if (m_rem == 0) begin m_st = S_POST; m_rem = POST - 1; end
          else begin m_st = S_RSTAB; m_rem = m_rem - 1; end
        S_POST: if (m_rem == 0) m_st = S_RUN; else m_rem = m_rem - 1;
        S_RUN: if (stop_req) m_st = S_STOP;
        S_STOP:
          if (a && (wake_level || m_run_cnt >= 1)) begin
            m_st = S_WSTAB; m_rem = (mode_fast ? WFAST : LONG) - 1;
          end
        S_WSTAB:
          if (wake_level && !a) m_st = S_STOP;
          else if (m_rem == 0) m_st = S_RUN;
          else m_rem = m_rem - 1;
        default: m_st = S_RESET;
      endcase
      m_run_cnt = (a && old == S_STOP) ? ((m_run_cnt < 1) ? m_run_cnt + 1 : 1) : 0;
      m_s2 = m_s1; m_s1 = wake_n;
    end
    m_fetch = (m_st == S_RUN) && (old != S_RUN);
    m_run   = (m_st == S_RUN);
    m_float = (m_st == S_RESET) || (m_st == S_RSTAB) || (m_st == S_POST);
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (m_st >= 0 && !done) begin
      check(seq_state == 3'(m_st), cur_req, "seq_state", seq_state, m_st);
      check(core_run == m_run, cur_req, "core_run", core_run, m_run);
      check(fetch_start == m_fetch, cur_req, "fetch_start", fetch_start, m_fetch);
      check(bus_float == (!ext_rst_n || m_float), cur_req, "bus_float", bus_float,
            int'(!ext_rst_n || m_float));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait (cycles >= 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    finish_run();
  end

  task automatic drive_wait(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic measure_fetch(input int exp_n, input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fetch_start && n < 2000);
    check(n == exp_n, req, "cycles to fetch_start", n, exp_n);
    #1;
  endtask

  initial begin
    // R1 / R2: long reset held beyond the long count, then R3 post delay
    cur_req = "R2";
    drive_wait(1);
    check(bus_float == 1'b1, "R1", "bus_float in reset", bus_float, 1);
    drive_wait(2);
    check(seq_state == 3'd1 && !core_run, "R1", "reset state", seq_state, 1);
    drive_wait(LONG + 10);
    cur_req = "R3";
    ext_rst_n = 1'b1;
    measure_fetch(POST + 1, "R3");
    cur_req = "R5";
    drive_wait(3);
    check(core_run && !fetch_start, "R5", "run after single pulse", core_run, 1);

    // R6: stop from RUN
    cur_req = "R6";
    stop_req = 1'b1;
    drive_wait(1);
    check(seq_state == 3'd4 && !core_run, "R6", "stop entered", seq_state, 4);
    drive_wait(5);
    check(seq_state == 3'd4, "R6", "stop_req ignored in STOP", seq_state, 4);
    stop_req = 1'b0;

    // R7: one-cycle edge pulse rejected
    cur_req = "R7";
    mode_fast = 1'b1;
    wake_n = 1'b0;
    drive_wait(1);
    wake_n = 1'b1;
    drive_wait(10);
    check(seq_state == 3'd4, "R7", "short pulse ignored", seq_state, 4);

    // R8: held edge wake, fast count
    cur_req = "R8";
    wake_n = 1'b0;
    measure_fetch(WFAST + 4, "R8");
    wake_n = 1'b1;
    drive_wait(4);
    stop_req = 1'b1;
    drive_wait(1);
    stop_req = 1'b0;
    drive_wait(4);

    // R9: level wake released mid-count, then full restart with long count
    cur_req = "R9";
    wake_level = 1'b1;
    mode_fast = 1'b0;
    wake_n = 1'b0;
    drive_wait(50);
    wake_n = 1'b1;
    drive_wait(6);
    check(seq_state == 3'd4, "R9", "released level wake back to STOP", seq_state, 4);
    wake_n = 1'b0;
    fork
      measure_fetch(LONG + 3, "R9");
      begin
        drive_wait(20);
        stop_req = 1'b1;   // R6: ignored in WSTAB
        drive_wait(10);
        stop_req = 1'b0;
      end
    join
    wake_n = 1'b1;
    drive_wait(3);
    stop_req = 1'b1;
    drive_wait(1);
    stop_req = 1'b0;
    drive_wait(3);

    // R1: reset during a wake has priority
    cur_req = "R1";
    wake_n = 1'b0;
    drive_wait(10);
    ext_rst_n = 1'b0;
    #0.5;
    check(bus_float == 1'b1, "R1", "bus_float immediate", bus_float, 1);
    wake_n = 1'b1;
    wake_level = 1'b0;
    drive_wait(3);
    ext_rst_n = 1'b1;
    drive_wait(1);

    // R4 / R2: fast reset released early, mode changed after entry
    cur_req = "R4";
    mode_fast = 1'b1;
    ext_rst_n = 1'b0;
    drive_wait(3);
    mode_fast = 1'b0;
    drive_wait(37);
    ext_rst_n = 1'b1;
    drive_wait(1);
    check(seq_state == 3'd2, "R4", "early release enters RSTAB", seq_state, 2);
    measure_fetch(RFAST - 40 + POST, "R4");
    drive_wait(4);
    check(seq_state == 3'd0, "R10", "RUN code", seq_state, 0);
    finish_run();
  end
endmodule